// File: doc/BRIEF.md
# Parallel ADC Host Controller

This block sits on the system side of a 12-bit, 8-channel successive-approximation converter with a parallel data bus. On a conversion request it pulses the active-low convert-start strobe. It then follows the converter's BUSY flag through a synchronizer and reads the result back with chip-select and read strobes. It returns the result as a 16-bit word with a one-cycle valid pulse, along with the coding mode that was used.

The result can be fetched in one of two ways. In word mode a single 12-bit read is made. In byte mode the controller makes two reads and uses a high-byte enable output to pick the half. The low eight bits are read first and the upper four second, and the two are joined into one word.

A control-word write request sends a 12-bit word to the converter using chip-select, the write strobe and a driven data bus. Every setup, pulse-width, hold, gap and recovery time is a parameter counted in system-clock cycles.

Top module: `adc_par_host`

## Requirements
- R1: While reset is held, and in the first cycle after it, convst_no, cs_no, rd_no and wr_no are high. In the same window hben_o, db_oe_o and valid_o are low and ready_o is high.
- R2: A start_i request accepted while ready_o is high drives convst_no low for exactly CONVST_CYC cycles. Any start_i or cfg_wr_i that arrives while ready_o is low is ignored.
- R3: No read begins until the synchronized BUSY has been seen high and then low. rd_no is never low while busy_i is high, and the first read strobe falls no sooner than 3 cycles after busy_i falls.
- R4: In word mode (byte_mode_i=0 at the request) exactly one read is made, with cs_no and rd_no low for RD_CYC cycles and hben_o low. The value on db_i[11:0] in the last cycle of that read is the result.
- R5: In byte mode (byte_mode_i=1) the first read has hben_o=0 and gives the low eight result bits from db_i[7:0]. Strobes then stay high for GAP_CYC cycles. The second read has hben_o=1 and gives result bits 11:8 from db_i[3:0]. Each read lasts RD_CYC cycles.
- R6: With twos_comp_i=0 at the request, result_o is the 12-bit value zero-extended to 16 bits. With twos_comp_i=1, bit 11 is copied into bits 15:12. coding_o shows the setting that was latched at the request.
- R7: valid_o is high for exactly one cycle per conversion. It rises in the cycle after the final read strobe ends, and result_o holds its value until the next conversion completes.
- R8: After the final read strobe rises, ready_o stays low for exactly RECOV_CYC = max(QUIET_CYC, FLOAT_CYC) cycles. No convert-start or bus drive can happen before the converter has released the bus.
- R9: A cfg_wr_i request drives cs_no low and db_oe_o high with db_o equal to cfg_data_i. Then WR_SETUP_CYC cycles pass before wr_no falls, wr_no stays low for WR_CYC cycles, and the data stays driven for WR_HOLD_CYC cycles after wr_no rises.
- R10: If cfg_wr_i and start_i are both high in the same idle cycle, the write is carried out and the start is dropped.
- R11: rd_no and wr_no are never low together, cs_no is low whenever either strobe is low, and db_oe_o is never high while rd_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken when ready_o is high |
| cfg_wr_i | input | 1 | Control-word write request, taken when ready_o is high |
| cfg_data_i | input | 12 | Control word to write |
| byte_mode_i | input | 1 | 1 selects two byte reads, 0 a single word read |
| twos_comp_i | input | 1 | 1 selects sign extension of the result |
| busy_i | input | 1 | Converter BUSY flag, asynchronous |
| db_i | input | 12 | Data bus from the converter |
| db_o | output | 12 | Data bus driven toward the converter |
| db_oe_o | output | 1 | Drive enable for db_o |
| convst_no | output | 1 | Active-low convert-start strobe |
| cs_no | output | 1 | Active-low chip select |
| rd_no | output | 1 | Active-low read strobe |
| wr_no | output | 1 | Active-low write strobe |
| hben_o | output | 1 | High-byte enable for byte reads |
| result_o | output | 16 | Conversion result, zero- or sign-extended |
| valid_o | output | 1 | One-cycle pulse when result_o is updated |
| coding_o | output | 1 | Coding mode that goes with result_o |
| ready_o | output | 1 | Controller idle and able to accept a request |

## Verification
Errors in the state sequencing show up on the strobes within one transaction. A timer loaded with the wrong count makes a convert-start, read, gap, write or recovery window one cycle too long or too short, and the bench measures each of these windows directly. A wrong capture point or a bad join of the two bytes shows up in result_o at the very next valid pulse, because the bus model puts distinct filler on the unused bits and between reads. A mishandled BUSY wait shows up as a read strobe overlapping BUSY, or falling too soon after BUSY drops, in that same conversion.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CNV,
    ST_BSY_HI,
    ST_BSY_LO,
    ST_RD_LO,
    ST_RD_GAP,
    ST_RD_HI,
    ST_RECOV,
    ST_WR_SU,
    ST_WR_LO,
    ST_WR_HD,
    ST_WR_GAP
  } host_state_e;
endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_host_assemble.sv
module adc_host_assemble #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic [DATA_W-1:0] bus_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              byte_mode_i,
  input  logic              twos_i,
  output logic [OUT_W-1:0]  word_o
);
  localparam int HI_W  = DATA_W - BYTE_W;
  localparam int EXT_W = OUT_W - DATA_W;

  logic [DATA_W-1:0] raw;

  always_comb begin
    if (byte_mode_i) raw = {bus_i[HI_W-1:0], lo_i};
    else             raw = bus_i;
  end

  // sign or zero fill of the upper bits
  assign word_o = {{EXT_W{twos_i & raw[DATA_W-1]}}, raw};
endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
  import adc_host_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int BYTE_W       = 8,
  parameter int OUT_W        = 16,
  parameter int CW           = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int CONVST_CYC   = 2,
  parameter int RD_CYC       = 6,
  parameter int GAP_CYC      = 2,
  parameter int QUIET_CYC    = 6,
  parameter int FLOAT_CYC    = 10,
  parameter int WR_SETUP_CYC = 2,
  parameter int WR_CYC       = 2,
  parameter int WR_HOLD_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              byte_mode_i,
  input  logic              twos_comp_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] db_o,
  output logic              db_oe_o,
  output logic              convst_no,
  output logic              cs_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              hben_o,
  output logic [OUT_W-1:0]  result_o,
  output logic              valid_o,
  output logic              coding_o,
  output logic              ready_o
);
  localparam int RECOV_CYC = (QUIET_CYC > FLOAT_CYC) ? QUIET_CYC : FLOAT_CYC;

  host_state_e       state_q, state_d;
  logic              busy_s;
  logic              tmr_load, tmr_done;
  logic [CW-1:0]     tmr_val;
  logic              byte_q, twos_q;
  logic [DATA_W-1:0] cfg_q;
  logic [BYTE_W-1:0] lo_q;
  logic [OUT_W-1:0]  asm_word;
  logic [OUT_W-1:0]  result_q;
  logic              valid_q, coding_q;

  adc_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (busy_i),
    .q_o    (busy_s)
  );

  adc_host_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  adc_host_assemble #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .OUT_W  (OUT_W)
  ) u_asm (
    .bus_i       (db_i),
    .lo_i        (lo_q),
    .byte_mode_i (byte_q),
    .twos_i      (twos_q),
    .word_o      (asm_word)
  );

  // length of each timed state, minus one
  function automatic logic [CW-1:0] dur_of(host_state_e s);
    case (s)
      ST_CNV:    dur_of = CW'(CONVST_CYC - 1);
      ST_RD_LO:  dur_of = CW'(RD_CYC - 1);
      ST_RD_HI:  dur_of = CW'(RD_CYC - 1);
      ST_RD_GAP: dur_of = CW'(GAP_CYC - 1);
      ST_RECOV:  dur_of = CW'(RECOV_CYC - 1);
      ST_WR_SU:  dur_of = CW'(WR_SETUP_CYC - 1);
      ST_WR_LO:  dur_of = CW'(WR_CYC - 1);
      ST_WR_HD:  dur_of = CW'(WR_HOLD_CYC - 1);
      ST_WR_GAP: dur_of = CW'(GAP_CYC - 1);
      default:   dur_of = '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (cfg_wr_i)     state_d = ST_WR_SU;
        else if (start_i) state_d = ST_CNV;
      end
      ST_CNV:    if (tmr_done) state_d = ST_BSY_HI;
      ST_BSY_HI: if (busy_s)   state_d = ST_BSY_LO;
      ST_BSY_LO: if (!busy_s)  state_d = ST_RD_LO;
      ST_RD_LO:  if (tmr_done) state_d = byte_q ? ST_RD_GAP : ST_RECOV;
      ST_RD_GAP: if (tmr_done) state_d = ST_RD_HI;
      ST_RD_HI:  if (tmr_done) state_d = ST_RECOV;
      ST_RECOV:  if (tmr_done) state_d = ST_IDLE;
      ST_WR_SU:  if (tmr_done) state_d = ST_WR_LO;
      ST_WR_LO:  if (tmr_done) state_d = ST_WR_HD;
      ST_WR_HD:  if (tmr_done) state_d = ST_WR_GAP;
      ST_WR_GAP: if (tmr_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = dur_of(state_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request attributes latched at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= 1'b0;
      twos_q <= 1'b0;
      cfg_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      if (cfg_wr_i) begin
        cfg_q <= cfg_data_i;
      end else if (start_i) begin
        byte_q <= byte_mode_i;
        twos_q <= twos_comp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
      coding_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tmr_done && state_q == ST_RD_LO && byte_q) begin
        lo_q <= db_i[BYTE_W-1:0];
      end
      if (tmr_done && ((state_q == ST_RD_LO && !byte_q) || state_q == ST_RD_HI)) begin
        result_q <= asm_word;
        coding_q <= twos_q;
        valid_q  <= 1'b1;
      end
    end
  end

  logic rd_act, wr_act;
  assign rd_act = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign wr_act = (state_q == ST_WR_SU) || (state_q == ST_WR_LO) || (state_q == ST_WR_HD);

  assign convst_no = (state_q != ST_CNV);
  assign rd_no     = !rd_act;
  assign wr_no     = (state_q != ST_WR_LO);
  assign cs_no     = !(rd_act || wr_act);
  assign hben_o    = (state_q == ST_RD_HI);
  assign db_oe_o   = wr_act;
  assign db_o      = cfg_q;
  assign result_o  = result_q;
  assign valid_o   = valid_q;
  assign coding_o  = coding_q;
  assign ready_o   = (state_q == ST_IDLE);
endmodule

// File: rtl/adc_par_host_chk.sv
module adc_par_host_chk #(
  parameter int DATA_W     = 12,
  parameter int OUT_W      = 16,
  parameter int CONVST_CYC = 2,
  parameter int RD_CYC     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             convst_no,
  input logic             cs_no,
  input logic             rd_no,
  input logic             wr_no,
  input logic             db_oe_o,
  input logic             hben_o,
  input logic             valid_o,
  input logic             coding_o,
  input logic [OUT_W-1:0] result_o
);
  logic [7:0] cnv_low_cnt, rd_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_low_cnt <= '0;
      rd_low_cnt  <= '0;
    end else begin
      cnv_low_cnt <= !convst_no ? ((cnv_low_cnt == 8'hFF) ? cnv_low_cnt : cnv_low_cnt + 1'b1) : '0;
      rd_low_cnt  <= !rd_no ? ((rd_low_cnt == 8'hFF) ? rd_low_cnt : rd_low_cnt + 1'b1) : '0;
    end
  end

  // R2
  convst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_no) |-> (cnv_low_cnt == 8'(CONVST_CYC)));

  // R4
  rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> (rd_low_cnt == 8'(RD_CYC)));

  // R5
  hben_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && $past(!rd_no)) |-> $stable(hben_o));

  // R6
  sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o[OUT_W-1:DATA_W] ==
                 (coding_o ? {(OUT_W-DATA_W){result_o[DATA_W-1]}} : '0)));

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> db_oe_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  // R11
  cs_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !cs_no);

  // R11
  bus_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !db_oe_o);
endmodule

bind adc_par_host adc_par_host_chk #(
  .DATA_W     (DATA_W),
  .OUT_W      (OUT_W),
  .CONVST_CYC (CONVST_CYC),
  .RD_CYC     (RD_CYC)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .convst_no (convst_no),
  .cs_no     (cs_no),
  .rd_no     (rd_no),
  .wr_no     (wr_no),
  .db_oe_o   (db_oe_o),
  .hben_o    (hben_o),
  .valid_o   (valid_o),
  .coding_o  (coding_o),
  .result_o  (result_o)
);

// File: tb/adc_par_host_tb_top.sv
`timescale 1ns/1ps
module adc_par_host_tb_top;
  localparam int CONVST_CYC = 2;
  localparam int RD_CYC     = 6;
  localparam int GAP_CYC    = 2;
  localparam int QUIET_CYC  = 6;
  localparam int FLOAT_CYC  = 10;
  localparam int WS_CYC     = 2;
  localparam int WL_CYC     = 2;
  localparam int WH_CYC     = 2;
  localparam int RECOV_CYC  = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, cfg_wr_i = 1'b0;
  logic [11:0] cfg_data_i = '0;
  logic        byte_mode_i = 1'b0, twos_comp_i = 1'b0;
  logic        busy_i = 1'b0;
  logic [11:0] db_i;
  logic [11:0] db_o;
  logic        db_oe_o, convst_no, cs_no, rd_no, wr_no, hben_o;
  logic [15:0] result_o;
  logic        valid_o, coding_o, ready_o;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  logic [11:0] adc_word = '0;
  bit          model_byte = 0;

  always #2.5 clk = ~clk;

  adc_par_host dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cfg_wr_i(cfg_wr_i),
    .cfg_data_i(cfg_data_i), .byte_mode_i(byte_mode_i), .twos_comp_i(twos_comp_i),
    .busy_i(busy_i), .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o),
    .convst_no(convst_no), .cs_no(cs_no), .rd_no(rd_no), .wr_no(wr_no),
    .hben_o(hben_o), .result_o(result_o), .valid_o(valid_o),
    .coding_o(coding_o), .ready_o(ready_o)
  );

  // converter bus model: filler outside reads and on unused bits
  always_comb begin
    if (!rd_no && !cs_no) begin
      if (model_byte) db_i = hben_o ? {8'hC3, adc_word[11:8]} : {4'hF, adc_word[7:0]};
      else            db_i = adc_word;
    end else begin
      db_i = 12'h5A5;
    end
  end

  // converter BUSY model
  always @(negedge convst_no) begin
    #7 busy_i = 1'b1;
    repeat (20) @(posedge clk);
    #1 busy_i = 1'b0;
  end

  // monitors, sampled at the falling clock edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic p_cnv = 1, p_rd = 1, p_wr = 1, p_busy = 0, p_oe = 0, p_ready = 1, p_valid = 0;
  int cnv_cnt = 0, cnv_len = 0, cnv_falls = 0;
  int rd_cnt = 0, rd_len = 0, rd_lens[2], rd_idx = 0, gap_cnt = 0, gap_len = 0;
  bit hben_r[2];
  int busy_fall_cyc = 0, rd_fall_cyc = 0, rd_busy_overlap = 0;
  int rec_cnt = 0, rec_len = 0;
  int su_cnt = 0, wl_cnt = 0, wh_cnt = 0, wr_falls = 0;
  bit wr_seen = 0;
  logic [11:0] wr_data = '0;
  int val_len = 0, val_cnt = 0;

  always @(negedge clk) begin
    if (!convst_no) cnv_cnt++;
    if (convst_no && !p_cnv) cnv_len = cnv_cnt;
    if (!convst_no && p_cnv) begin cnv_falls++; cnv_cnt = 1; end
    if (!busy_i && p_busy) busy_fall_cyc = cyc;
    if (!rd_no && busy_i) rd_busy_overlap++;
    if (!rd_no && p_rd) begin
      if (rd_idx == 0) rd_fall_cyc = cyc;
      if (rd_idx > 0) gap_len = gap_cnt;
      if (rd_idx < 2) hben_r[rd_idx] = hben_o;
      rd_cnt = 0;
    end
    if (!rd_no) begin rd_cnt++; rec_cnt = 0; end
    if (rd_no && !p_rd) begin
      if (rd_idx < 2) rd_lens[rd_idx] = rd_cnt;
      rd_idx++; gap_cnt = 0;
    end
    if (rd_no) gap_cnt++;
    if (rd_no && !ready_o) rec_cnt++;
    if (ready_o && !p_ready) rec_len = rec_cnt;
    if (ready_o) rec_cnt = 0;
    if (db_oe_o && !p_oe) begin su_cnt = 0; wl_cnt = 0; wh_cnt = 0; wr_seen = 0; end
    if (db_oe_o && wr_no && !wr_seen) su_cnt++;
    if (db_oe_o && !wr_no) begin wl_cnt++; wr_seen = 1; end
    if (db_oe_o && wr_no && wr_seen) wh_cnt++;
    if (!wr_no && p_wr) wr_falls++;
    if (wr_no && !p_wr) wr_data = db_o;
    if (valid_o) begin val_len++; if (!p_valid) val_cnt++; end
    if (!valid_o && p_valid) val_len = 0;
    p_cnv = convst_no; p_rd = rd_no; p_wr = wr_no; p_busy = busy_i;
    p_oe = db_oe_o; p_ready = ready_o; p_valid = valid_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500 && !ready_o; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    #1;
    chk(convst_no && cs_no && rd_no && wr_no, "R1", "strobes in reset", {convst_no, cs_no, rd_no, wr_no}, 4'hF);
    chk(!hben_o && !db_oe_o && !valid_o && ready_o, "R1", "flags in reset", {hben_o, db_oe_o, valid_o, ready_o}, 4'h1);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(convst_no && cs_no && rd_no && wr_no, "R1", "strobes after reset", {convst_no, cs_no, rd_no, wr_no}, 4'hF);
    chk(!valid_o && ready_o, "R1", "idle after reset", {valid_o, ready_o}, 2'b01);
  endtask

  task automatic do_convert(input logic [11:0] w, input bit bm, input bit tc,
                            input logic [15:0] exp, input string req);
    int falls0, vals0, wrf0;
    falls0 = cnv_falls; vals0 = val_cnt; wrf0 = wr_falls;
    adc_word = w; model_byte = bm; rd_idx = 0;
    @(negedge clk);
    start_i = 1'b1; byte_mode_i = bm; twos_comp_i = tc;
    @(negedge clk);
    start_i = 1'b0; byte_mode_i = ~bm; twos_comp_i = ~tc;
    for (int i = 0; i < 500 && !valid_o; i++) @(negedge clk);
    chk(result_o == exp, req, "result", result_o, exp);
    chk(coding_o == tc, "R6", "coding", coding_o, tc);
    chk(rd_no, "R7", "valid after final read", rd_no, 1);
    wait_ready();
    repeat (2) @(negedge clk);
    chk(cnv_falls == falls0 + 1, "R2", "one convert-start", cnv_falls - falls0, 1);
    chk(cnv_len == CONVST_CYC, "R2", "convst width", cnv_len, CONVST_CYC);
    chk(rd_fall_cyc - busy_fall_cyc >= 3, "R3", "read after busy fall", rd_fall_cyc - busy_fall_cyc, 3);
    chk(rd_busy_overlap == 0, "R3", "read while busy", rd_busy_overlap, 0);
    chk(rd_idx == (bm ? 2 : 1), bm ? "R5" : "R4", "read count", rd_idx, bm ? 2 : 1);
    chk(rd_lens[0] == RD_CYC, "R4", "read width", rd_lens[0], RD_CYC);
    chk(hben_r[0] == 1'b0, "R4", "first read hben", hben_r[0], 0);
    if (bm) begin
      chk(rd_lens[1] == RD_CYC, "R5", "second read width", rd_lens[1], RD_CYC);
      chk(gap_len == GAP_CYC, "R5", "gap between reads", gap_len, GAP_CYC);
      chk(hben_r[1] == 1'b1, "R5", "second read hben", hben_r[1], 1);
    end
    chk(val_cnt == vals0 + 1, "R7", "valid pulses", val_cnt - vals0, 1);
    chk(rec_len == RECOV_CYC, "R8", "recovery", rec_len, RECOV_CYC);
    chk(wr_falls == wrf0, "R11", "no write during conversion", wr_falls - wrf0, 0);
    chk(result_o == exp, "R7", "result held", result_o, exp);
  endtask

  task automatic do_write(input logic [11:0] d);
    int wrf0;
    wrf0 = wr_falls;
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_data_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0; cfg_data_i = ~d;
    wait_ready();
    @(negedge clk);
    chk(wr_falls == wrf0 + 1, "R9", "one write strobe", wr_falls - wrf0, 1);
    chk(su_cnt == WS_CYC, "R9", "write setup", su_cnt, WS_CYC);
    chk(wl_cnt == WL_CYC, "R9", "write width", wl_cnt, WL_CYC);
    chk(wh_cnt == WH_CYC, "R9", "write hold", wh_cnt, WH_CYC);
    chk(wr_data == d, "R9", "write data", wr_data, d);
  endtask

  task automatic test_ignore();
    int falls0, wrf0;
    falls0 = cnv_falls; wrf0 = wr_falls;
    adc_word = 12'h123; model_byte = 0;
    @(negedge clk); start_i = 1'b1; byte_mode_i = 0; twos_comp_i = 0;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 100 && !busy_i; i++) @(negedge clk);
    start_i = 1'b1; cfg_wr_i = 1'b1;
    @(negedge clk); start_i = 1'b0; cfg_wr_i = 1'b0;
    for (int i = 0; i < 500 && !valid_o; i++) @(negedge clk);
    chk(result_o == 16'h0123, "R2", "result with ignored requests", result_o, 16'h0123);
    wait_ready();
    repeat (5) @(negedge clk);
    chk(cnv_falls == falls0 + 1, "R2", "start ignored while busy", cnv_falls - falls0, 1);
    chk(wr_falls == wrf0, "R2", "write ignored while busy", wr_falls - wrf0, 0);
  endtask

  task automatic test_priority();
    int falls0, wrf0;
    falls0 = cnv_falls; wrf0 = wr_falls;
    @(negedge clk);
    start_i = 1'b1; cfg_wr_i = 1'b1; cfg_data_i = 12'h3A6;
    @(negedge clk);
    start_i = 1'b0; cfg_wr_i = 1'b0;
    wait_ready();
    repeat (5) @(negedge clk);
    chk(wr_falls == wrf0 + 1, "R10", "write taken", wr_falls - wrf0, 1);
    chk(cnv_falls == falls0, "R10", "start dropped", cnv_falls - falls0, 0);
    chk(wr_data == 12'h3A6, "R10", "write data", wr_data, 12'h3A6);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    test_reset();
    do_convert(12'h9A5, 0, 0, 16'h09A5, "R4");
    do_convert(12'h9A5, 0, 1, 16'hF9A5, "R6");
    do_convert(12'h3C1, 0, 1, 16'h03C1, "R6");
    do_convert(12'hB7E, 1, 0, 16'h0B7E, "R5");
    do_convert(12'h812, 1, 1, 16'hF812, "R5");
    do_convert(12'h7FF, 1, 1, 16'h07FF, "R5");
    do_write(12'h5C3);
    do_write(12'hA3C);
    test_ignore();
    test_priority();
    do_convert(12'hFFF, 0, 1, 16'hFFFF, "R6");
    finish_run();
  end
endmodule